// File: doc/BRIEF.md
# Hot-Plug Slot Register Controller

This block holds the slot capability, slot control and slot status registers of a downstream port that supports adapter hot-plug. Software reaches them through a dword-wide configuration access port with per-byte enables. The slot side of the block takes three inputs. The first is an attention-button pulse. The second is a set of adapter add, remove and present-at-boot requests. The third carries the message-interrupt enables and the 5-bit interrupt message number of the port.

Each control write counts as one command and finishes in the same cycle, so command-completed is set at once. Bit 11 of the control register never holds a value. Writing 1 to it flips the interlock-engaged status bit. The block works out one notification level from the enabled events. It raises an interrupt only when that level changes. The interrupt goes out as a message request when MSI-X or MSI is enabled, and otherwise as a legacy INTx level. An event that lands while the master enable is off is therefore signalled later, when software turns the master enable on.

Top module: `hp_slot_ctrl`

## Requirements
- R1: After reset, the slot dword reads 0x000003C0. That is all status bits 0, both indicator fields (control bits 7:6 and 9:8) set to Off = 11, and every enable 0. INTx, irq_msg and plug_busy are all 0.
- R2: The capability dword at index 0 is read-only. It reads the slot number in bits 31:19, plus bits 17 (interlock present), 6 (hot-plug capable), 5 (surprise), 4 (power indicator), 3 (attention indicator) and 0 (button present).
- R3: A write to the slot dword with either low byte enabled is one command. It updates the writable control bits (0, 3, 4, 5, 7:6, 9:8) of the enabled bytes and sets status bit 4 (command completed). Any status written by the same access is cleared first.
- R4: Control bit 11 always reads 0. Writing 1 to it, with byte 1 enabled, toggles status bit 7 (interlock engaged), which is dword bit 23.
- R5: Status bits 0, 3 and 4 (dword bits 16, 19, 20) clear when 1 is written to them with the byte enabled. Writing 0 leaves them unchanged. A status-only write updates the stored level without sending a message.
- R6: The level is control bit 5 AND any of {status & control} over bits 0, 3 and 4. When the level differs from its previous value (rising or falling) and MSI-X or MSI is enabled, irq_msg pulses for one cycle on the clock edge that takes the update. With that pulse, irq_vector shows msg_num and irq_msix shows msix_en.
- R7: An event whose status bit is already set, or a repeated control write that leaves the level the same, produces no new message.
- R8: With both message enables low, intx takes the new level when the level changes. A status write that leaves the level false drives intx to 0.
- R9: While status bit 7 is 1, card_add and card_remove are refused: plug_busy pulses and presence does not change. Otherwise card_add sets status bit 6 (present) and card_remove clears it, and both set status bit 3. card_add wins if both are asserted.
- R10: card_boot sets status bit 6 without setting status bit 3 and without any interrupt.
- R11: btn_press sets status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Config write strobe |
| cfg_rd | input | 1 | Config read strobe |
| cfg_addr | input | ADDR_W | Dword index (0 capability, 1 control/status) |
| cfg_be | input | 4 | Byte enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| cfg_rvalid | output | 1 | Read data valid, one cycle after cfg_rd |
| msg_num | input | 5 | Interrupt message number |
| msix_en | input | 1 | MSI-X enabled |
| msi_en | input | 1 | MSI enabled |
| btn_press | input | 1 | Attention button pulse |
| card_add | input | 1 | Adapter insertion request |
| card_remove | input | 1 | Adapter removal request |
| card_boot | input | 1 | Adapter present at power-up |
| plug_busy | output | 1 | Add/remove refused, interlock engaged |
| irq_msg | output | 1 | One-cycle message request |
| irq_msix | output | 1 | Message request uses MSI-X |
| irq_vector | output | 5 | Vector of the message request |
| intx | output | 1 | Legacy interrupt level |

## Verification
Some properties hold on every cycle, and the embedded assertions check those. After a command, command-completed is set. An interlock write flips the interlock status. A refused request leaves presence unchanged. A button press sets its status bit. A message appears only when message mode was on, and carries the MSI-X flag correctly. INTx rises only together with the stored level. Other behaviour needs a sequence of accesses, and only the bench scenarios can show it. That includes deferred delivery of an event raised while masked, silent clears, the absence of repeat messages, the read-back values of the fields, and the boot-presence path. A behavioural model in the bench covers those cases.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
  localparam int DW = 32;
  localparam int HW = 16;

  // control field positions
  localparam int CTL_ABPE = 0;
  localparam int CTL_PDCE = 3;
  localparam int CTL_CCIE = 4;
  localparam int CTL_HPIE = 5;
  localparam int CTL_EIC  = 11;

  // status field positions
  localparam int ST_ABP = 0;
  localparam int ST_PDC = 3;
  localparam int ST_CC  = 4;
  localparam int ST_PDS = 6;
  localparam int ST_EIS = 7;

  localparam logic [HW-1:0] CTL_STORE_MASK = 16'h03F9;
  localparam logic [HW-1:0] CTL_RESET      = 16'h03C0;
  localparam logic [HW-1:0] EVT_MASK       = 16'h0019;
  localparam logic [HW-1:0] W1C_MASK       = 16'h0019;
  localparam logic [DW-1:0] CAP_FIXED      = 32'h0002_0079;

  typedef struct packed {
    logic add;
    logic rem;
    logic cold;
    logic button;
  } plug_req_t;

  function automatic logic hp_level(input logic [HW-1:0] c, input logic [HW-1:0] s);
    return c[CTL_HPIE] & (|(c & s & EVT_MASK));
  endfunction
endpackage

// File: rtl/hp_slot_cfg_decode.sv
module hp_slot_cfg_decode
  import hp_slot_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int SLOT_IDX = 1
) (
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        be,
  input  logic [DW-1:0]     wdata,
  output logic              ctl_hit,
  output logic              sts_hit,
  output logic [HW-1:0]     ctl_bmask,
  output logic [HW-1:0]     ctl_wbits,
  output logic [HW-1:0]     sts_wbits
);
  localparam int NBYTES = DW / 8;

  logic [DW-1:0] bmask;
  logic          sel;

  for (genvar b = 0; b < NBYTES; b++) begin : g_bmask
    assign bmask[8*b +: 8] = {8{be[b]}};
  end

  assign sel       = wr && (addr == ADDR_W'(SLOT_IDX));
  assign ctl_hit   = sel && (|be[1:0]);
  assign sts_hit   = sel && (|be[3:2]);
  assign ctl_bmask = sel ? bmask[HW-1:0] : '0;
  assign ctl_wbits = wdata[HW-1:0] & ctl_bmask;
  assign sts_wbits = sel ? (wdata[DW-1:HW] & bmask[DW-1:HW]) : '0;
endmodule

// File: rtl/hp_slot_regs.sv
module hp_slot_regs
  import hp_slot_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_hit,
  input  logic          sts_hit,
  input  logic [HW-1:0] ctl_bmask,
  input  logic [HW-1:0] ctl_wbits,
  input  logic [HW-1:0] sts_wbits,
  input  plug_req_t     req,
  output logic [HW-1:0] ctl_q,
  output logic [HW-1:0] sts_q,
  output logic [HW-1:0] ctl_d,
  output logic [HW-1:0] sts_d,
  output logic          mid_level,
  output logic          busy_q
);
  logic [HW-1:0] s_clr;
  logic          busy_d;

  always_comb begin
    s_clr = sts_q;
    if (sts_hit) s_clr = sts_q & ~(sts_wbits & W1C_MASK);
    ctl_d = ctl_q;
    sts_d = s_clr;
    if (ctl_hit) begin
      ctl_d = (ctl_q & ~(ctl_bmask & CTL_STORE_MASK)) | (ctl_wbits & CTL_STORE_MASK);
      if (ctl_wbits[CTL_EIC]) sts_d[ST_EIS] = ~s_clr[ST_EIS];
      sts_d[ST_CC] = 1'b1;
    end
    if (req.button) sts_d[ST_ABP] = 1'b1;
    if (req.cold)   sts_d[ST_PDS] = 1'b1;
    busy_d = 1'b0;
    if (req.add || req.rem) begin
      if (sts_q[ST_EIS]) begin
        busy_d = 1'b1;
      end else begin
        sts_d[ST_PDS] = req.add;
        sts_d[ST_PDC] = 1'b1;
      end
    end
    mid_level = hp_level(ctl_q, s_clr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= CTL_RESET;
      sts_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      ctl_q  <= ctl_d;
      sts_q  <= sts_d;
      busy_q <= busy_d;
    end
  end

  // R3
  cmd_sets_cc_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_hit |=> sts_q[ST_CC]);

  // R4
  eis_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_hit && ctl_wbits[CTL_EIC]) |=> (sts_q[ST_EIS] != $past(sts_q[ST_EIS])));

  // R9
  busy_keeps_pds_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !$past(req.cold)) |-> $stable(sts_q[ST_PDS]));

  // R11
  button_sets_abp_chk: assert property (@(posedge clk) disable iff (rst)
    req.button |=> sts_q[ST_ABP]);
endmodule

// File: rtl/hp_slot_notify.sv
module hp_slot_notify
  import hp_slot_pkg::*;
#(
  parameter int VEC_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [HW-1:0]    ctl_d,
  input  logic [HW-1:0]    sts_d,
  input  logic             mid_level,
  input  logic             sts_hit,
  input  logic             msix_en,
  input  logic             msi_en,
  input  logic [VEC_W-1:0] msg_num,
  output logic             irq_msg,
  output logic             irq_msix,
  output logic [VEC_W-1:0] irq_vector,
  output logic             intx,
  output logic             level_q
);
  logic fin_level;
  logic base_level;
  logic changed;
  logic msg_mode;

  assign fin_level  = hp_level(ctl_d, sts_d);
  assign base_level = sts_hit ? mid_level : level_q;
  assign changed    = fin_level != base_level;
  assign msg_mode   = msix_en | msi_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q    <= 1'b0;
      irq_msg    <= 1'b0;
      irq_msix   <= 1'b0;
      irq_vector <= '0;
      intx       <= 1'b0;
    end else begin
      level_q <= fin_level;
      irq_msg <= changed && msg_mode;
      if (changed && msg_mode) begin
        irq_msix   <= msix_en;
        irq_vector <= msg_num;
      end
      if (!msg_mode) begin
        if (changed)                     intx <= fin_level;
        else if (sts_hit && !mid_level)  intx <= 1'b0;
      end
    end
  end

  // R6
  msg_needs_mode_chk: assert property (@(posedge clk) disable iff (rst)
    irq_msg |-> $past(msix_en || msi_en));

  // R6
  msix_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_msg && $past(msix_en)) |-> irq_msix);

  // R8
  intx_rise_level_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(intx) |-> level_q);
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hp_slot_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int CAP_IDX  = 0,
  parameter int SLOT_IDX = 1,
  parameter int SLOT_NUM = 5,
  parameter int VEC_W    = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              cfg_rvalid,
  input  logic [VEC_W-1:0]  msg_num,
  input  logic              msix_en,
  input  logic              msi_en,
  input  logic              btn_press,
  input  logic              card_add,
  input  logic              card_remove,
  input  logic              card_boot,
  output logic              plug_busy,
  output logic              irq_msg,
  output logic              irq_msix,
  output logic [VEC_W-1:0]  irq_vector,
  output logic              intx
);
  localparam logic [12:0]   SLOT_BITS = 13'(SLOT_NUM);
  localparam logic [DW-1:0] CAP_VALUE = {SLOT_BITS, 19'd0} | CAP_FIXED;

  logic          ctl_hit, sts_hit, mid_level, level_q;
  logic [HW-1:0] ctl_bmask, ctl_wbits, sts_wbits;
  logic [HW-1:0] ctl_q, sts_q, ctl_d, sts_d;
  plug_req_t     req;

  assign req = '{add: card_add, rem: card_remove, cold: card_boot, button: btn_press};

  hp_slot_cfg_decode #(.ADDR_W(ADDR_W), .SLOT_IDX(SLOT_IDX)) u_dec (
    .wr(cfg_wr), .addr(cfg_addr), .be(cfg_be), .wdata(cfg_wdata),
    .ctl_hit(ctl_hit), .sts_hit(sts_hit), .ctl_bmask(ctl_bmask),
    .ctl_wbits(ctl_wbits), .sts_wbits(sts_wbits)
  );

  hp_slot_regs u_regs (
    .clk(clk), .rst(rst), .ctl_hit(ctl_hit), .sts_hit(sts_hit),
    .ctl_bmask(ctl_bmask), .ctl_wbits(ctl_wbits), .sts_wbits(sts_wbits),
    .req(req), .ctl_q(ctl_q), .sts_q(sts_q), .ctl_d(ctl_d), .sts_d(sts_d),
    .mid_level(mid_level), .busy_q(plug_busy)
  );

  hp_slot_notify #(.VEC_W(VEC_W)) u_ntf (
    .clk(clk), .rst(rst), .ctl_d(ctl_d), .sts_d(sts_d),
    .mid_level(mid_level), .sts_hit(sts_hit), .msix_en(msix_en),
    .msi_en(msi_en), .msg_num(msg_num), .irq_msg(irq_msg),
    .irq_msix(irq_msix), .irq_vector(irq_vector), .intx(intx),
    .level_q(level_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rvalid <= 1'b0;
      cfg_rdata  <= '0;
    end else begin
      cfg_rvalid <= cfg_rd;
      if (cfg_rd) begin
        if (cfg_addr == ADDR_W'(CAP_IDX))       cfg_rdata <= CAP_VALUE;
        else if (cfg_addr == ADDR_W'(SLOT_IDX)) cfg_rdata <= {sts_q, ctl_q};
        else                                    cfg_rdata <= '0;
      end
    end
  end

  // R4
  eic_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_rvalid && $past(cfg_addr == ADDR_W'(SLOT_IDX))) |-> !cfg_rdata[CTL_EIC]);
endmodule

// File: tb/hp_slot_ctrl_test.sv
`timescale 1ns/1ps
module hp_slot_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 0, cfg_rd = 0;
  logic [1:0]  cfg_addr = 0;
  logic [3:0]  cfg_be = 0;
  logic [31:0] cfg_wdata = 0;
  logic [31:0] cfg_rdata;
  logic        cfg_rvalid;
  logic [4:0]  msg_num = 0;
  logic        msix_en = 0, msi_en = 0;
  logic        btn_press = 0, card_add = 0, card_remove = 0, card_boot = 0;
  logic        plug_busy, irq_msg, irq_msix, intx;
  logic [4:0]  irq_vector;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // reference model state
  logic [15:0] m_ctl, m_sts;
  logic        m_lvl, m_msg, m_msix, m_intx, m_busy, m_rvalid;
  logic [4:0]  m_vec;
  logic [31:0] m_rdata;
  logic [31:0] v;
  localparam logic [31:0] CAP_EXP = 32'h002A_0079;

  always #5 clk = ~clk;

  hp_slot_ctrl uut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cfg_rvalid(cfg_rvalid), .msg_num(msg_num), .msix_en(msix_en),
    .msi_en(msi_en), .btn_press(btn_press), .card_add(card_add),
    .card_remove(card_remove), .card_boot(card_boot), .plug_busy(plug_busy),
    .irq_msg(irq_msg), .irq_msix(irq_msix), .irq_vector(irq_vector), .intx(intx)
  );

  function automatic logic lvl(input logic [15:0] c, input logic [15:0] s);
    logic any;
    any = (c[0] && s[0]) || (c[3] && s[3]) || (c[4] && s[4]);
    return c[5] && any;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_tick();
    logic [15:0] c, s;
    logic [31:0] wm;
    logic mid, fin, base, ct, st;
    if (rst) begin
      m_ctl = 16'h03C0; m_sts = 0; m_lvl = 0; m_msg = 0; m_msix = 0;
      m_intx = 0; m_busy = 0; m_rvalid = 0; m_rdata = 0; m_vec = 0;
      return;
    end
    m_rvalid = cfg_rd;
    if (cfg_rd) m_rdata = (cfg_addr == 0) ? CAP_EXP : (cfg_addr == 1) ? {m_sts, m_ctl} : 32'h0;
    wm = 0;
    for (int i = 0; i < 4; i++) if (cfg_be[i]) wm[i*8 +: 8] = 8'hFF;
    ct = cfg_wr && cfg_addr == 1 && (cfg_be[0] || cfg_be[1]);
    st = cfg_wr && cfg_addr == 1 && (cfg_be[2] || cfg_be[3]);
    c = m_ctl; s = m_sts;
    if (st) for (int b = 0; b < 16; b++)
      if ((b == 0 || b == 3 || b == 4) && wm[16+b] && cfg_wdata[16+b]) s[b] = 1'b0;
    mid = lvl(c, s);
    if (ct) begin
      for (int b = 0; b < 16; b++)
        if (wm[b] && (b inside {0, 3, 4, 5, 6, 7, 8, 9})) c[b] = cfg_wdata[b];
      if (wm[11] && cfg_wdata[11]) s[7] = !s[7];
      s[4] = 1'b1;
    end
    if (btn_press) s[0] = 1'b1;
    if (card_boot) s[6] = 1'b1;
    m_busy = 0;
    if (card_add || card_remove) begin
      if (m_sts[7]) m_busy = 1;
      else begin s[6] = card_add; s[3] = 1'b1; end
    end
    fin = lvl(c, s);
    base = st ? mid : m_lvl;
    m_msg = (fin != base) && (msix_en || msi_en);
    if (m_msg) begin m_vec = msg_num; m_msix = msix_en; end
    if (!(msix_en || msi_en)) begin
      if (fin != base) m_intx = fin;
      else if (st && !mid) m_intx = 0;
    end
    m_lvl = fin; m_ctl = c; m_sts = s;
  endtask

  task automatic step();
    model_tick();
    @(posedge clk);
    @(negedge clk);
    chk("R6 per-cycle irq_msg", irq_msg, m_msg);
    chk("R8 per-cycle intx", intx, m_intx);
    chk("R9 per-cycle plug_busy", plug_busy, m_busy);
    chk("R2 per-cycle rvalid", cfg_rvalid, m_rvalid);
    if (m_rvalid) chk("R2 per-cycle rdata", cfg_rdata, m_rdata);
    if (m_msg) begin
      chk("R6 per-cycle vector", irq_vector, m_vec);
      chk("R6 per-cycle msix", irq_msix, m_msix);
    end
  endtask

  task automatic wr(input logic [3:0] be, input logic [31:0] d);
    cfg_wr = 1; cfg_addr = 1; cfg_be = be; cfg_wdata = d;
    step();
    cfg_wr = 0; cfg_be = 0; cfg_wdata = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    cfg_rd = 1; cfg_addr = a;
    step();
    cfg_rd = 0;
    d = cfg_rdata;
  endtask

  task automatic do_reset();
    rst = 1; step(); step(); rst = 0;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    chk("R1 intx after reset", intx, 0);
    rd(1, v); chk("R1 reset slot dword", v, 32'h0000_03C0);
    rd(0, v); chk("R2 capability dword", v, CAP_EXP);
    wr(4'b0011, 32'h0); rd(0, v); chk("R2 capability unchanged", v, CAP_EXP);

    msi_en = 1; msg_num = 5'd17;
    wr(4'b0011, 32'h0000_03F9);
    chk("R6 msg on rise", irq_msg, 1); chk("R6 vector", irq_vector, 17);
    rd(1, v); chk("R3 cc after command", v, 32'h0010_03F9);
    wr(4'b0011, 32'h0000_03F9);
    chk("R7 no repeat msg", irq_msg, 0);
    wr(4'b1100, 32'h0);
    rd(1, v); chk("R5 zero write keeps status", v, 32'h0010_03F9);
    wr(4'b1100, 32'h0010_0000);
    chk("R5 silent clear", irq_msg, 0);
    rd(1, v); chk("R5 cc cleared", v, 32'h0000_03F9);

    btn_press = 1; step(); btn_press = 0;
    chk("R11 button msg", irq_msg, 1);
    rd(1, v); chk("R11 abp set", v, 32'h0001_03F9);
    btn_press = 1; step(); btn_press = 0;
    chk("R7 button repeat no msg", irq_msg, 0);

    wr(4'b0001, 32'h0000_00D9);
    chk("R6 msg on fall", irq_msg, 1);
    wr(4'b1100, 32'h0019_0000);
    btn_press = 1; step(); btn_press = 0;
    chk("R6 masked no msg", irq_msg, 0);
    wr(4'b0001, 32'h0000_00F9);
    chk("R6 deferred msg on unmask", irq_msg, 1);

    msi_en = 0;
    wr(4'b1100, 32'h0019_0000);
    chk("R8 intx low after clear", intx, 0);
    btn_press = 1; step(); btn_press = 0;
    chk("R8 intx follows level", intx, 1);
    chk("R8 no msg in legacy", irq_msg, 0);
    wr(4'b1100, 32'h0001_0000);
    chk("R8 intx deassert on status write", intx, 0);

    wr(4'b0010, 32'h0000_0B00);
    rd(1, v); chk("R4 eis toggled, eic reads 0", v, 32'h0090_03F9);
    card_add = 1; step(); card_add = 0;
    chk("R9 busy while locked", plug_busy, 1);
    rd(1, v); chk("R9 presence unchanged", v, 32'h0090_03F9);
    wr(4'b1100, 32'h0010_0000);
    wr(4'b0010, 32'h0000_0B00);
    rd(1, v); chk("R4 eis toggled back", v, 32'h0010_03F9);
    card_add = 1; step(); card_add = 0;
    chk("R9 add accepted", plug_busy, 0);
    rd(1, v); chk("R9 add sets pds and pdc", v, 32'h0058_03F9);
    wr(4'b1100, 32'h0018_0000);
    chk("R8 intx cleared", intx, 0);

    msix_en = 1; msg_num = 5'd3;
    card_remove = 1; step(); card_remove = 0;
    chk("R9 remove msg", irq_msg, 1); chk("R6 msix flag", irq_msix, 1);
    chk("R6 msix vector", irq_vector, 3);
    rd(1, v); chk("R9 remove clears pds", v, 32'h0008_03F9);

    msix_en = 0;
    do_reset();
    card_boot = 1; step(); card_boot = 0;
    chk("R10 boot no msg", irq_msg, 0); chk("R10 boot no intx", intx, 0);
    rd(1, v); chk("R10 boot sets pds only", v, 32'h0040_03C0);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule